// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the rising edges of that signal over a gate window of known length. Raising the `start` control begins a measurement. A settling delay of four millisecond ticks comes first, so the window opens 3 to 4 ms after the request. The count then runs for 4, 8, 16 or 32 ticks, chosen by `gate_sel`. The result is kept on the `count` bus until `start` is lowered, which clears it and returns the block to idle.

A shared status pin, modelled as the `pin_low` open-drain pull-down, reports one of several conditions, chosen by a 3-bit code. The conditions are: the end of a measurement, a PLL unlock indication, signal-detect and stereo. The unlock condition has three modes. It can be switched off, passed through directly, or held for a further one to two millisecond ticks after the last phase-error pulse. While the serial bus is busy, the pin is always released.

The controller has four states: `ST_IDLE`, `ST_SETTLE`, `ST_GATE` and `ST_HOLD`.

| From | To | Condition |
|------|----|-----------|
| `ST_IDLE` | `ST_SETTLE` | `start` is high |
| `ST_SETTLE` | `ST_GATE` | the fourth tick arrives |
| `ST_GATE` | `ST_HOLD` | the last gate tick arrives |
| `ST_SETTLE`, `ST_GATE`, `ST_HOLD` | `ST_IDLE` | `start` is low |

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset, `count` is 0, `sat` is 0 and the controller is idle, so select code 010 leaves the pin released.
- R2: A low `start` in any state makes `count` and `sat` read 0 from the next clock edge. It also returns the controller to idle, and there select code 010 releases the pin.
- R3: When `start` is high in idle, the block first waits for four `ms_tick` pulses. Rising edges of `if_in` during this wait are not counted.
- R4: `gate_sel` is latched when the measurement starts. The codes 00, 01, 10 and 11 keep the gate open for 4, 8, 16 and 32 ticks after the wait.
- R5: Each rising edge of `if_in` seen in the gate window adds one to `count`. The counter is `CNT_W` bits wide, with a default of 20.
- R6: At the all-ones value, `count` stops instead of wrapping, and a further edge sets `sat`. `sat` stays set until the next clear.
- R7: After the gate closes, `count` and `sat` stay fixed while `start` remains high, whatever `if_in` and `ms_tick` do.
- R8: With select code 010, the pin is released from the start of a measurement until the gate closes. It is pulled low once the measurement has finished.
- R9: Select code 101 pulls the pin low while `sig_det` is 1. Code 110 pulls it low while `stereo` is 1. Codes 000, 011, 100 and 111 always release it.
- R10: Select code 001 shows the unlock indication, whose behaviour depends on `ulk_mode`. Mode 00 never reports unlock. Mode 01 reports while `phase_err` is high. Modes 1x also keep reporting until two more ticks have passed after the last `phase_err`.
- R11: While `bus_busy` is 1, the pin is released whatever the select code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| if_in | input | 1 | IF signal, synchronous to `clk` |
| start | input | 1 | 1 runs a measurement, 0 clears it |
| gate_sel | input | 2 | Gate length code |
| pin_sel | input | 3 | Status pin source select |
| ulk_mode | input | 2 | Unlock reporting mode |
| phase_err | input | 1 | Phase error outside the lock window |
| sig_det | input | 1 | Signal-detect on |
| stereo | input | 1 | Stereo pilot detected |
| bus_busy | input | 1 | Serial transfer in progress |
| count | output | CNT_W | Measured edge count |
| sat | output | 1 | Count saturated |
| pin_low | output | 1 | 1 pulls the status pin low |

## Verification
Two things can fall on the same clock edge: the tick that ends the settling wait and the handover to counting. An `if_in` pulse is also driven in every settling period, so an early opening of the window would add edges to the total. A second collision is between the last gate tick and the count reaching all ones. Vectors with eight pulses per tick over a 32-tick gate drive an 8-bit counter past its limit inside the window. The bench then checks that the count stops at 255 with `sat` set, and that the completion status still appears on the following edge.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_GATE,
        ST_HOLD
    } ifc_state_e;

    localparam logic [2:0] SEL_UNLOCK = 3'b001;
    localparam logic [2:0] SEL_END    = 3'b010;
    localparam logic [2:0] SEL_SD     = 3'b101;
    localparam logic [2:0] SEL_STEREO = 3'b110;
endpackage

// File: rtl/ifc_edge_count.sv
module ifc_edge_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (clr) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (en) begin
            if (&count) begin
                sat <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ifc_unlock_stretch.sv
module ifc_unlock_stretch #(
    parameter int STRETCH_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       phase_err,
    input  logic       ms_tick,
    output logic       unlock_ind
);
    localparam int SW = $clog2(STRETCH_TICKS + 1);

    logic [SW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (phase_err) begin
            hold_cnt <= SW'(STRETCH_TICKS);
        end else if (ms_tick && hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            2'b00:   unlock_ind = 1'b0;
            2'b01:   unlock_ind = phase_err;
            default: unlock_ind = phase_err | (hold_cnt != '0);
        endcase
    end
endmodule

// File: rtl/ifc_status_mux.sv
module ifc_status_mux
    import ifc_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       bus_busy,
    input  logic       unlock_ind,
    input  logic       meas_end,
    input  logic       sig_det,
    input  logic       stereo,
    output logic       pull_low
);
    logic chosen;

    always_comb begin
        unique case (sel)
            SEL_UNLOCK: chosen = unlock_ind;
            SEL_END:    chosen = meas_end;
            SEL_SD:     chosen = sig_det;
            SEL_STEREO: chosen = stereo;
            default:    chosen = 1'b0;
        endcase
        pull_low = chosen & ~bus_busy;
    end
endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
    import ifc_pkg::*;
#(
    parameter int CNT_W         = 20,
    parameter int WAIT_TICKS    = 4,
    parameter int GATE_BASE     = 4,
    parameter int STRETCH_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             if_in,
    input  logic             start,
    input  logic [1:0]       gate_sel,
    input  logic [2:0]       pin_sel,
    input  logic [1:0]       ulk_mode,
    input  logic             phase_err,
    input  logic             sig_det,
    input  logic             stereo,
    input  logic             bus_busy,
    output logic [CNT_W-1:0] count,
    output logic             sat,
    output logic             pin_low
);
    localparam int GATE_MAX = GATE_BASE << 3;
    localparam int TC_W     = $clog2(GATE_MAX) + 1;

    ifc_state_e    state, state_n;
    logic [TC_W-1:0] tick_cnt;
    logic [1:0]    gate_q;
    logic [TC_W-1:0] gate_len;
    logic          if_q;
    logic          if_rise;
    logic          cnt_clr, cnt_en, meas_end;
    logic          wait_done, gate_done;
    logic          unlock_ind;

    assign gate_len  = TC_W'(GATE_BASE) << gate_q;
    assign wait_done = ms_tick && (tick_cnt == TC_W'(WAIT_TICKS - 1));
    assign gate_done = ms_tick && (tick_cnt == gate_len - 1'b1);
    assign if_rise   = if_in & ~if_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = ST_SETTLE;
            ST_SETTLE: if (!start) state_n = ST_IDLE;
                       else if (wait_done) state_n = ST_GATE;
            ST_GATE:   if (!start) state_n = ST_IDLE;
                       else if (gate_done) state_n = ST_HOLD;
            ST_HOLD:   if (!start) state_n = ST_IDLE;
        endcase
    end

    // tick counter, gate latch, input edge register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            gate_q   <= 2'b00;
            if_q     <= 1'b0;
        end else begin
            if_q <= if_in;
            if (state == ST_IDLE && start) gate_q <= gate_sel;
            if (state_n != state || state == ST_IDLE) tick_cnt <= '0;
            else if (ms_tick) tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // outputs of the controller
    always_comb begin
        cnt_clr  = !start || state == ST_IDLE || state == ST_SETTLE;
        cnt_en   = (state == ST_GATE) && if_rise;
        meas_end = (state == ST_HOLD);
    end

    ifc_edge_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .count (count),
        .sat   (sat)
    );

    ifc_unlock_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_ulk (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (ulk_mode),
        .phase_err  (phase_err),
        .ms_tick    (ms_tick),
        .unlock_ind (unlock_ind)
    );

    ifc_status_mux u_mux (
        .sel        (pin_sel),
        .bus_busy   (bus_busy),
        .unlock_ind (unlock_ind),
        .meas_end   (meas_end),
        .sig_det    (sig_det),
        .stereo     (stereo),
        .pull_low   (pin_low)
    );
endmodule

// File: rtl/ifc_gated_counter_chk.sv
module ifc_gated_counter_chk
    import ifc_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       pin_sel,
    input logic [1:0]       ulk_mode,
    input logic             bus_busy,
    input logic [CNT_W-1:0] count,
    input logic             sat,
    input logic             pin_low
);
    p_clear_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (count == '0 && !sat));

    p_no_decrease_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!start || count >= $past(count)));

    p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && start) |=> sat);

    p_sat_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> (&count));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == SEL_END && pin_low && start) |=> $stable(count));

    p_open_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == 3'b000 || pin_sel == 3'b011 || pin_sel == 3'b100 || pin_sel == 3'b111)
        |-> !pin_low);

    p_unlock_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == SEL_UNLOCK && ulk_mode == 2'b00) |-> !pin_low);

    p_busy_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> !pin_low);
endmodule

bind ifc_gated_counter ifc_gated_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pin_sel  (pin_sel),
    .ulk_mode (ulk_mode),
    .bus_busy (bus_busy),
    .count    (count),
    .sat      (sat),
    .pin_low  (pin_low)
);

// File: tb/ifc_gated_counter_test.sv
module ifc_gated_counter_test;
    localparam int CNT_W = 8;
    localparam int TICK  = 20;
    localparam int NVEC  = 7;
    localparam int MAXV  = (1 << CNT_W) - 1;

    // {gate_sel, pulses per tick period}
    localparam logic [5:0] VEC [0:NVEC-1] = '{
        {2'd0, 4'd3}, {2'd1, 4'd5}, {2'd2, 4'd2}, {2'd3, 4'd7},
        {2'd3, 4'd8}, {2'd2, 4'd8}, {2'd0, 4'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ms_tick = 1'b0, if_in = 1'b0, start = 1'b0;
    logic [1:0]       gate_sel = 2'b00;
    logic [2:0]       pin_sel = 3'b010;
    logic [1:0]       ulk_mode = 2'b00;
    logic             phase_err = 1'b0, sig_det = 1'b0, stereo = 1'b0, bus_busy = 1'b0;
    logic [CNT_W-1:0] count;
    logic             sat, pin_low;
    int               n_chk = 0;
    int               n_err = 0;

    always #4 clk = ~clk;

    ifc_gated_counter #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .if_in(if_in), .start(start),
        .gate_sel(gate_sel), .pin_sel(pin_sel), .ulk_mode(ulk_mode),
        .phase_err(phase_err), .sig_det(sig_det), .stereo(stereo),
        .bus_busy(bus_busy), .count(count), .sat(sat), .pin_low(pin_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_periods(input int nper, input int k);
        for (int p = 0; p < nper; p++) begin
            for (int c = 0; c < TICK; c++) begin
                @(negedge clk);
                ms_tick = (c == TICK - 1);
                if_in   = (c >= 2) && (c <= 2 * k) && (c % 2 == 0);
            end
        end
    endtask

    task automatic quiet_cycle();
        @(negedge clk);
        ms_tick = 1'b0;
        if_in   = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 count after reset", int'(count), 0);
        chk("R1 sat after reset", int'(sat), 0);
        chk("R1 pin after reset", int'(pin_low), 0);

        // vector walk: R3 pulses in wait periods ignored, R4 gate length, R5/R6 count
        for (int v = 0; v < NVEC; v++) begin
            int g, k, raw, exp_cnt, exp_sat;
            g = int'(VEC[v][5:4]);
            k = int'(VEC[v][3:0]);
            raw = k * (4 << g);
            exp_cnt = (raw > MAXV) ? MAXV : raw;
            exp_sat = (raw > MAXV) ? 1 : 0;
            @(negedge clk);
            gate_sel = VEC[v][5:4];
            start = 1'b1;
            run_periods(5, k);
            #1;
            chk("R8 pin released during gate", int'(pin_low), 0);
            run_periods((4 << g) - 1, k);
            quiet_cycle();
            #1;
            chk("R8 pin low after gate end", int'(pin_low), 1);
            chk("R3 R4 R5 count", int'(count), exp_cnt);
            chk("R6 sat flag", int'(sat), exp_sat);
            if (v != NVEC - 1) begin
                @(negedge clk);
                start = 1'b0;
                @(negedge clk);
                #1;
                chk("R2 count cleared by stop", int'(count), 0);
                chk("R2 pin open in idle", int'(pin_low), 0);
            end
        end

        // R7: restart with a known result, then keep pulsing
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        gate_sel = 2'b00;
        start = 1'b1;
        run_periods(8, 4);
        quiet_cycle();
        run_periods(3, 6);
        quiet_cycle();
        #1;
        chk("R7 count held after gate", int'(count), 16);
        chk("R7 done held", int'(pin_low), 1);

        // R11: bus busy releases the pin
        bus_busy = 1'b1;
        #1;
        chk("R11 busy releases pin", int'(pin_low), 0);
        bus_busy = 1'b0;
        #1;
        chk("R11 pin returns after busy", int'(pin_low), 1);

        // R9: select codes
        sig_det = 1'b1;
        stereo  = 1'b1;
        pin_sel = 3'b101;
        #1;
        chk("R9 signal-detect low", int'(pin_low), 1);
        pin_sel = 3'b110;
        #1;
        chk("R9 stereo low", int'(pin_low), 1);
        stereo = 1'b0;
        #1;
        chk("R9 stereo off open", int'(pin_low), 0);
        stereo = 1'b1;
        ulk_mode = 2'b01;
        phase_err = 1'b1;
        foreach (VEC[i]) begin end
        pin_sel = 3'b000;
        #1;
        chk("R9 code 000 open", int'(pin_low), 0);
        pin_sel = 3'b011;
        #1;
        chk("R9 code 011 open", int'(pin_low), 0);
        pin_sel = 3'b100;
        #1;
        chk("R9 code 100 open", int'(pin_low), 0);
        pin_sel = 3'b111;
        #1;
        chk("R9 code 111 open", int'(pin_low), 0);
        phase_err = 1'b0;
        sig_det = 1'b0;
        stereo = 1'b0;

        // R10: unlock modes
        @(negedge clk);
        pin_sel = 3'b001;
        ulk_mode = 2'b00;
        phase_err = 1'b1;
        #1;
        chk("R10 mode off stays open", int'(pin_low), 0);
        ulk_mode = 2'b01;
        #1;
        chk("R10 direct reports", int'(pin_low), 1);
        phase_err = 1'b0;
        #1;
        chk("R10 direct follows error", int'(pin_low), 0);
        @(negedge clk);
        ulk_mode = 2'b10;
        phase_err = 1'b1;
        @(negedge clk);
        phase_err = 1'b0;
        #1;
        chk("R10 stretched after error", int'(pin_low), 1);
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        #1;
        chk("R10 stretched after one tick", int'(pin_low), 1);
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        #1;
        chk("R10 released after two ticks", int'(pin_low), 0);

        // R2: abort in the middle of the gate
        @(negedge clk);
        pin_sel = 3'b010;
        start = 1'b0;
        @(negedge clk);
        gate_sel = 2'b00;
        start = 1'b1;
        run_periods(6, 4);
        #1;
        chk("R5 partial count in gate", int'(count), 8);
        @(negedge clk);
        ms_tick = 1'b0;
        start = 1'b0;
        @(negedge clk);
        #1;
        chk("R2 abort clears count", int'(count), 0);
        chk("R2 abort leaves pin open", int'(pin_low), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule